// File: doc/BRIEF.md
# Label-Filtering Serial Avionics Word Receiver

This block is a single receive channel for a two-wire return-to-zero avionics data line. It recovers the bit clock from the line itself, assembles 32-bit words that arrive least significant bit first, and checks odd parity and bit count. Each good word is then looked up in an acceptance table that the host loads. The table is indexed by the word's 2-bit source/destination field and its 8-bit label. Accepted words go into a receive FIFO.

The host sees a small register window on a parameterised data bus of 8, 16 or 32 bits. Through it the host sets the channel's enable, its line rate and its interrupt enable, loads the acceptance table, and reads received words one bus-width slice at a time. It also reads the FIFO status and clears the two sticky error flags. The interrupt output is high while words are waiting and interrupts are enabled.

Top module: `arx_rx_channel`

## Requirements
- R1: Line state (A=1,B=0) is a one bit, (A=0,B=1) is a zero bit, and any other state is null. Each bit is a non-null pulse followed by null. Bits fill the word from bit 0 upward. A word ends once the line has been null for GAP_BITS bit times, and at that point it must hold exactly 32 bits.
- R2: CTRL (address 0) bit 1 sets the rate. A 1 gives high speed, with OSR*HI_DIV clocks per bit. A 0 gives low speed, with OSR*LO_DIV clocks per bit. CTRL bit 0 enables the channel and bit 2 enables the interrupt. All CTRL bits read back and are 0 after reset.
- R3: A 32-bit word whose bits do not have odd parity overall is discarded and sets the sticky error flag, STAT bit 4.
- R4: A word that ends with fewer or more than 32 bits is discarded and sets STAT bit 4.
- R5: The label is word[7:0] and the SDI field is word[9:8]. A good word is buffered only if its label is below LABELS and the table entry at index {SDI, label[LBL_W-1:0]} is 1. All entries are 0 after reset.
- R6: The host writes a table entry in two steps. It writes the index to TIDX (address 3), then writes wr_data[0] to TBIT (address 2). A TBIT write is ignored while the channel is enabled.
- R7: Words leave the FIFO in arrival order. Reading address 4+k returns bits [k*DW +: DW] of the oldest word. A read of the last slice, address 4+32/DW-1, removes that word.
- R8: STAT bit 0 is empty, bit 1 is half-full (count at least FIFO_DEPTH/2) and bit 2 is full. After reset STAT reads 0x01.
- R9: An accepted word that arrives while the FIFO is full is dropped and sets the sticky overflow flag, STAT bit 3. Words already buffered are unchanged.
- R10: Writing STAT with bit 3 or bit 4 set clears the matching sticky flag.
- R11: irq is 1 exactly while CTRL bit 2 is set and the FIFO is not empty.
- R12: While the channel is disabled, line activity produces no word and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_a | input | 1 | Line receiver output, A wire |
| line_b | input | 1 | Line receiver output, B wire |
| addr | input | 3 | Host register address |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Host write data |
| rd_en | input | 1 | Host read strobe (pops on last data slice) |
| rd_data | output | DW | Host read data, combinational from addr |
| irq | output | 1 | Interrupt: words waiting and enabled |

## Verification
The line inputs pass through two synchroniser flops. A word is then judged on the oversampling tick that completes GAP_BITS null bit times after its last pulse. Its FIFO entry, the empty flag and irq change on the following clock edge. The bench therefore checks status only after holding the line null for six bit times behind each word, which leaves margin for the synchroniser and tick phase. Register reads are combinational, so every read is sampled 1 ns after the address changes at a falling edge. A pop takes effect at the next rising edge, and the monitor re-tests irq only after that edge.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;
  // line symbol recovered from the two wires
  typedef enum logic [1:0] {SYM_NULL = 2'd0, SYM_ZERO = 2'd1, SYM_ONE = 2'd2} sym_e;

  // host register addresses
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_TBIT = 3'd2;
  localparam logic [2:0] A_TIDX = 3'd3;

  function automatic sym_e line_sym(input logic a, input logic b);
    if (a && !b) return SYM_ONE;
    if (!a && b) return SYM_ZERO;
    return SYM_NULL;
  endfunction

  function automatic logic parity_ok(input logic [31:0] w);
    return ^w;
  endfunction

  function automatic logic [7:0] label_of(input logic [31:0] w);
    return w[7:0];
  endfunction

  function automatic logic [1:0] sdi_of(input logic [31:0] w);
    return w[9:8];
  endfunction
endpackage

// File: rtl/arx_bit_recover.sv
`timescale 1ns/1ps
module arx_bit_recover
  import arx_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int HI_DIV   = 10,
  parameter int LO_DIV   = 80,
  parameter int GAP_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hi_speed,
  input  logic line_a,
  input  logic line_b,
  output logic bit_stb,
  output logic bit_val,
  output logic gap_evt
);
  localparam int DIV_MAX   = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int CW        = $clog2(DIV_MAX + 1);
  localparam int GAP_TICKS = GAP_BITS * OSR;
  localparam int GW        = $clog2(GAP_TICKS + 1);

  logic [1:0]    sync_a, sync_b;
  logic [CW-1:0] div_cnt, div_lim;
  logic [GW-1:0] null_run;
  logic          tick, prev_null;
  sym_e          sym;

  assign div_lim = hi_speed ? CW'(HI_DIV - 1) : CW'(LO_DIV - 1);
  assign tick    = run && (div_cnt >= div_lim);
  assign sym     = line_sym(sync_a[1], sync_b[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[0], line_a};
      sync_b <= {sync_b[0], line_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      prev_null <= 1'b1;
      null_run  <= '0;
    end else if (!run) begin
      div_cnt   <= '0;
      prev_null <= 1'b1;
      null_run  <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        prev_null <= (sym == SYM_NULL);
        if (sym != SYM_NULL) null_run <= '0;
        else if (null_run != GW'(GAP_TICKS)) null_run <= null_run + 1'b1;
      end
    end
  end

  // a bit is the first non-null sample after a null sample
  assign bit_stb = tick && (sym != SYM_NULL) && prev_null;
  assign bit_val = (sym == SYM_ONE);
  // fires once, on the tick that completes the inter-word gap
  assign gap_evt = tick && (sym == SYM_NULL) && (null_run == GW'(GAP_TICKS - 1));
endmodule

// File: rtl/arx_word_asm.sv
`timescale 1ns/1ps
module arx_word_asm
  import arx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        bit_stb,
  input  logic        bit_val,
  input  logic        gap_evt,
  output logic [31:0] word,
  output logic        word_done,
  output logic        word_err
);
  logic [5:0] bit_cnt;
  logic       extra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
      extra   <= 1'b0;
    end else if (!run || gap_evt) begin
      bit_cnt <= '0;
      extra   <= 1'b0;
    end else if (bit_stb) begin
      if (bit_cnt == 6'd32) extra <= 1'b1;
      else begin
        word    <= {bit_val, word[31:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign word_done = gap_evt && (bit_cnt == 6'd32) && !extra && parity_ok(word);
  assign word_err  = gap_evt && (bit_cnt != 6'd0) && !word_done;
endmodule

// File: rtl/arx_fifo.sv
`timescale 1ns/1ps
module arx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         half,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign half    = (cnt >= (AW+1)'(DEPTH / 2));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/arx_rx_channel.sv
`timescale 1ns/1ps
module arx_rx_channel
  import arx_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LABELS     = 64,
  parameter int FIFO_DEPTH = 32,
  parameter int OSR        = 8,
  parameter int HI_DIV     = 10,
  parameter int LO_DIV     = 80,
  parameter int GAP_BITS   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_a,
  input  logic          line_b,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int LBL_W   = $clog2(LABELS);
  localparam int IDX_W   = LBL_W + 2;
  localparam int ENTRIES = 4 * LABELS;
  localparam int NSL     = 32 / DW;
  localparam int SLW     = (NSL > 1) ? $clog2(NSL) : 1;

  logic               ctrl_en, ctrl_hi, ctrl_ie, ovf_q, err_q;
  logic [ENTRIES-1:0] tbl_q;
  logic [IDX_W-1:0]   tidx_q, idx;
  logic               bit_stb, bit_val, gap_evt;
  logic [31:0]        word, head;
  logic               word_done, word_err, acc, in_range, pop, data_hit;
  logic               empty, half, full;
  logic [7:0]         lbl;
  logic [DW-1:0]      slices [NSL];

  arx_bit_recover #(.OSR(OSR), .HI_DIV(HI_DIV), .LO_DIV(LO_DIV), .GAP_BITS(GAP_BITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .hi_speed(ctrl_hi),
    .line_a(line_a), .line_b(line_b),
    .bit_stb(bit_stb), .bit_val(bit_val), .gap_evt(gap_evt)
  );

  arx_word_asm u_asm (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .bit_stb(bit_stb), .bit_val(bit_val),
    .gap_evt(gap_evt), .word(word), .word_done(word_done), .word_err(word_err)
  );

  // acceptance lookup on {SDI, label}
  assign lbl      = label_of(word);
  assign in_range = ({1'b0, lbl} < 9'(LABELS));
  assign idx      = {sdi_of(word), lbl[LBL_W-1:0]};
  assign acc      = word_done && in_range && tbl_q[idx];

  arx_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(acc), .din(word), .pop(pop),
    .head(head), .empty(empty), .half(half), .full(full)
  );

  // host read window: data slices at 4..4+NSL-1, last slice pops
  for (genvar g = 0; g < NSL; g++) begin : g_slice
    assign slices[g] = head[g*DW +: DW];
  end

  assign data_hit = addr[2] && (int'(addr[1:0]) < NSL);
  assign pop      = rd_en && addr[2] && (addr[1:0] == 2'(NSL - 1));

  always_comb begin
    rd_data = '0;
    if (data_hit)            rd_data = slices[addr[SLW-1:0]];
    else if (addr == A_CTRL) rd_data = DW'({ctrl_ie, ctrl_hi, ctrl_en});
    else if (addr == A_STAT) rd_data = DW'({err_q, ovf_q, full, half, empty});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctrl_ie, ctrl_hi, ctrl_en} <= '0;
      tidx_q <= '0;
      tbl_q  <= '0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) {ctrl_ie, ctrl_hi, ctrl_en} <= wr_data[2:0];
      if (wr_en && addr == A_TIDX) tidx_q <= IDX_W'(wr_data);
      if (wr_en && addr == A_TBIT && !ctrl_en) tbl_q[tidx_q] <= wr_data[0];
      if (word_err) err_q <= 1'b1;
      else if (wr_en && addr == A_STAT && wr_data[4]) err_q <= 1'b0;
      if (acc && full) ovf_q <= 1'b1;
      else if (wr_en && addr == A_STAT && wr_data[3]) ovf_q <= 1'b0;
    end
  end

  assign irq = ctrl_ie && !empty;
endmodule

// File: rtl/arx_rx_chk.sv
`timescale 1ns/1ps
module arx_rx_chk #(
  parameter int ENTRIES = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               acc,
  input logic               word_done,
  input logic               word_err,
  input logic               fifo_full,
  input logic               fifo_empty,
  input logic               ovf,
  input logic               err,
  input logic [ENTRIES-1:0] tbl
);
  // R8
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fifo_full) |=> ovf);

  // R7
  accepted_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !fifo_empty);

  // R3
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |=> err);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(word_done || word_err));

  // R6
  table_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(tbl));
endmodule

bind arx_rx_channel arx_rx_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .acc(acc), .word_done(word_done),
  .word_err(word_err), .fifo_full(full), .fifo_empty(empty), .ovf(ovf_q),
  .err(err_q), .tbl(tbl_q)
);

// File: tb/sim_arx_rx_channel.sv
`timescale 1ns/1ps
module sim_arx_rx_channel;
  localparam int P_OSR = 8;
  localparam int P_HI  = 4;
  localparam int P_LO  = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_a = 1'b0, line_b = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, failures = 0;
  bit mon_on = 0, mon_busy = 0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  arx_rx_channel #(.DW(8), .LABELS(64), .FIFO_DEPTH(4), .OSR(P_OSR),
                   .HI_DIV(P_HI), .LO_DIV(P_LO), .GAP_BITS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] lbl, input logic [1:0] sdi,
                                     input logic [18:0] dat, input logic good);
    logic [31:0] w;
    w = {1'b0, 2'b01, dat, sdi, lbl};
    w[31] = ~(^w[30:0]) ^ !good;
    return w;
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rd_data;
  endtask

  task automatic tbl_set(input logic [1:0] sdi, input logic [5:0] lbl, input logic v);
    bus_wr(3'd3, {sdi, lbl});
    bus_wr(3'd2, {7'd0, v});
  endtask

  // driver: drives one word on the line, then a null gap of six bit times
  task automatic send(input logic [31:0] w, input int nbits, input bit hi);
    int half = P_OSR * (hi ? P_HI : P_LO) / 2;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); line_a = w[i % 32]; line_b = !w[i % 32];
      repeat (half) @(negedge clk);
      line_a = 1'b0; line_b = 1'b0;
      repeat (half - 1) @(negedge clk);
    end
    repeat (12 * half) @(negedge clk);
  endtask

  task automatic send_exp(input logic [31:0] w, input bit hi);
    exp_q.push_back(w);
    send(w, 32, hi);
  endtask

  task automatic quiesce();
    mon_on = 0;
    repeat (3) @(negedge clk);
    while (mon_busy) @(negedge clk);
  endtask

  // monitor: on irq, reads four slices (last one pops) and compares to the scoreboard
  initial begin
    logic [31:0] got, e;
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        mon_busy = 1;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk); addr = 3'(4 + k); rd_en = (k == 3); #1;
          got[k*8 +: 8] = rd_data;
        end
        @(negedge clk); rd_en = 1'b0;
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected word buffered", got, 32'h0);
        else begin
          e = exp_q.pop_front();
          check(got == e, "R1 R7 word order and slices", got, e);
        end
        mon_busy = 0;
      end
    end
  end

  task automatic run_tests();
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    bus_rd(3'd1, d); check(d == 8'h01, "R8 reset status", d, 8'h01);
    bus_rd(3'd0, d); check(d == 8'h00, "R2 reset control", d, 8'h00);
    check(irq == 1'b0, "R11 reset irq", irq, 0);

    // table load while disabled
    tbl_set(2'd0, 6'h05, 1'b1);
    tbl_set(2'd2, 6'h21, 1'b1);
    tbl_set(2'd3, 6'h3F, 1'b1);
    tbl_set(2'd1, 6'h10, 1'b1);
    bus_wr(3'd0, 8'h07);
    bus_rd(3'd0, d); check(d == 8'h07, "R2 control readback", d, 8'h07);
    mon_on = 1;
    send_exp(mk(8'h05, 2'd0, 19'h12345, 1'b1), 1'b1);
    send_exp(mk(8'h21, 2'd2, 19'h7FFFF, 1'b1), 1'b1);
    send(mk(8'h10, 2'd2, 19'h00AA5, 1'b1), 32, 1'b1);  // R5 entry clear
    send_exp(mk(8'h3F, 2'd3, 19'h00000, 1'b1), 1'b1);
    send(mk(8'h45, 2'd0, 19'h01234, 1'b1), 32, 1'b1);  // R5 label out of range, aliases 0x05
    send(mk(8'h05, 2'd1, 19'h05555, 1'b1), 32, 1'b1);  // R5 other SDI
    send_exp(mk(8'h10, 2'd1, 19'h2AAAA, 1'b1), 1'b1);
    repeat (50) @(negedge clk);
    quiesce();
    check(exp_q.size() == 0, "R5 accepted words all delivered", exp_q.size(), 0);
    bus_rd(3'd1, d); check(d == 8'h01, "R5 rejected words not buffered", d, 8'h01);

    // parity and bit count errors
    send(mk(8'h05, 2'd0, 19'h11111, 1'b0), 32, 1'b1);
    bus_rd(3'd1, d); check(d == 8'h11, "R3 bad parity flagged, not buffered", d, 8'h11);
    bus_wr(3'd1, 8'h10);
    bus_rd(3'd1, d); check(d == 8'h01, "R10 error flag cleared", d, 8'h01);
    send(mk(8'h05, 2'd0, 19'h22222, 1'b1), 20, 1'b1);
    bus_rd(3'd1, d); check(d == 8'h11, "R4 short word flagged", d, 8'h11);
    bus_wr(3'd1, 8'h10);
    send(mk(8'h05, 2'd0, 19'h33333, 1'b1), 33, 1'b1);
    bus_rd(3'd1, d); check(d == 8'h11, "R4 long word flagged", d, 8'h11);
    bus_wr(3'd1, 8'h10);
    bus_rd(3'd1, d); check(d == 8'h01, "R10 error flag cleared again", d, 8'h01);

    // table write ignored while enabled, honoured while disabled
    tbl_set(2'd0, 6'h07, 1'b1);
    send(mk(8'h07, 2'd0, 19'h04444, 1'b1), 32, 1'b1);
    bus_rd(3'd1, d); check(d == 8'h01, "R6 write while enabled ignored", d, 8'h01);
    bus_wr(3'd0, 8'h00);
    tbl_set(2'd0, 6'h07, 1'b1);
    bus_wr(3'd0, 8'h07);
    mon_on = 1;
    send_exp(mk(8'h07, 2'd0, 19'h04444, 1'b1), 1'b1);

    // low speed
    quiesce();
    bus_wr(3'd0, 8'h05);
    mon_on = 1;
    send_exp(mk(8'h21, 2'd2, 19'h5A5A5, 1'b1), 1'b0);
    repeat (50) @(negedge clk);
    quiesce();
    check(exp_q.size() == 0, "R2 R6 low speed and loaded entry delivered", exp_q.size(), 0);

    // disabled channel
    bus_wr(3'd0, 8'h02);
    send(mk(8'h05, 2'd0, 19'h06666, 1'b1), 32, 1'b1);
    bus_rd(3'd1, d); check(d == 8'h01, "R12 disabled channel ignores line", d, 8'h01);

    // fill, half, full, overflow
    bus_wr(3'd0, 8'h03);
    send_exp(mk(8'h05, 2'd0, 19'h00001, 1'b1), 1'b1);
    send_exp(mk(8'h05, 2'd0, 19'h00002, 1'b1), 1'b1);
    bus_rd(3'd1, d); check(d == 8'h02, "R8 half full", d, 8'h02);
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    send_exp(mk(8'h05, 2'd0, 19'h00003, 1'b1), 1'b1);
    send_exp(mk(8'h05, 2'd0, 19'h00004, 1'b1), 1'b1);
    bus_rd(3'd1, d); check(d == 8'h06, "R8 full", d, 8'h06);
    send(mk(8'h05, 2'd0, 19'h00005, 1'b1), 32, 1'b1);
    bus_rd(3'd1, d); check(d == 8'h0E, "R9 overflow flagged", d, 8'h0E);
    bus_wr(3'd0, 8'h07);
    #1; check(irq == 1'b1, "R11 irq with words waiting", irq, 1);
    mon_on = 1;
    repeat (200) @(negedge clk);
    quiesce();
    check(exp_q.size() == 0, "R9 buffered words kept", exp_q.size(), 0);
    check(irq == 1'b0, "R11 irq drops when empty", irq, 0);
    bus_rd(3'd1, d); check(d == 8'h09, "R9 overflow sticky after drain", d, 8'h09);
    bus_wr(3'd1, 8'h08);
    bus_rd(3'd1, d); check(d == 8'h01, "R10 overflow cleared", d, 8'h01);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all R actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule